// File: doc/BRIEF.md
# Interrupt Controller Command Register Interface

This block is the software-facing register port of one 8-line interrupt controller unit. It sits between a byte-wide register bus and the unit's priority resolver. The bus has a one-bit address, a write strobe, a read strobe and separate 8-bit write and read buses. The block steps through the multi-byte initialization sequence and decodes run-time command bytes by their flag bits. It holds the mask register, the vector base and the mode bits. It sends the resolver single-cycle command strobes: end-of-interrupt, rotation, priority set and the initialization clear.

Reads go through the same port. The odd address returns the mask. The even address returns either the request or the in-service vector, both supplied by the resolver, or a poll result when a poll was armed. A poll read reports the resolver's winning line and acknowledges it back to the resolver. A separate trigger-mode register keeps only the bits allowed by a per-instance writable mask (F8h for a master unit, DEh for a slave unit). Priority resolution itself happens outside this block.

Top module: `pic_regif`

## Requirements
- R1: An even-address write with bit 4 set starts initialization. One cycle later imr, read_isr, special_mask, sfnm, auto_eoi and rot_aeoi are 0, the poll is disarmed, init_busy is 1, and init_clr is high for that one cycle.
- R2: The first odd-address write after initialization starts sets vec_base to the written byte with bits 2:0 forced to 0.
- R3: After the base byte, an odd write is taken as the cascade byte (into casc_cfg) only if the start byte had bit 1 clear. A further odd write is taken as the mode byte only if the start byte had bit 0 set. Once the last expected byte is written, init_busy returns to 0.
- R4: The mode byte sets sfnm from bit 4 and auto_eoi from bit 1.
- R5: With init_busy low, an odd-address write loads imr. An odd-address read returns imr.
- R6: An even-address write with bit 4 clear and bit 3 set is a select command. If bit 1 is set, read_isr takes bit 0. If bit 6 is set, special_mask takes bit 5. The poll is armed when bit 2 is set and disarmed when it is clear.
- R7: With no poll armed, an even-address read returns core_isr when read_isr is 1 and core_irr when read_isr is 0.
- R8: An even-address write with bits 4 and 3 clear is an order command whose bits 7:5 select the operation. 001 gives eoi_ns. 101 gives eoi_ns with eoi_rot. 011 gives eoi_sp. 111 gives eoi_sp with eoi_rot. 110 gives prio_set. 010 does nothing. For 011, 111 and 110, cmd_line takes bits 2:0. Each strobe is high for exactly the one cycle after the write.
- R9: Order command 100 sets rot_aeoi and order command 000 clears it; neither raises a strobe.
- R10: An even-address read with the poll armed returns 80h ORed with core_req_line when core_req_valid is 1, and 07h otherwise. In the cycle after the read, poll_ack equals core_req_valid and poll_line holds the line. The poll is then disarmed.
- R11: A trig_wr pulse loads trig_mode with trig_wdata ANDed with the TRIG_WMASK parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | Register address (0 even, 1 odd) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current read |
| core_irr | input | 8 | Request vector from the resolver |
| core_isr | input | 8 | In-service vector from the resolver |
| core_req_valid | input | 1 | Resolver has a winning line |
| core_req_line | input | 3 | Winning line number |
| trig_wr | input | 1 | Trigger-mode register write |
| trig_wdata | input | 8 | Trigger-mode write data |
| trig_mode | output | 8 | Trigger-mode register (1 = level) |
| imr | output | 8 | Interrupt mask |
| vec_base | output | 8 | Vector base, low 3 bits zero |
| casc_cfg | output | 8 | Cascade configuration byte |
| init_busy | output | 1 | Initialization sequence in progress |
| init_clr | output | 1 | One-cycle clear of the resolver's request, service and priority state |
| sfnm | output | 1 | Special fully nested mode |
| auto_eoi | output | 1 | Automatic end of interrupt |
| rot_aeoi | output | 1 | Rotate on automatic end of interrupt |
| read_isr | output | 1 | Even reads return the in-service vector |
| special_mask | output | 1 | Special mask mode |
| eoi_ns | output | 1 | Non-specific end-of-interrupt strobe |
| eoi_sp | output | 1 | Specific end-of-interrupt strobe |
| eoi_rot | output | 1 | Rotate qualifier for the EOI strobe |
| prio_set | output | 1 | Set-lowest-priority strobe |
| cmd_line | output | 3 | Line for specific EOI or priority set |
| poll_ack | output | 1 | Poll acknowledge strobe |
| poll_line | output | 3 | Line acknowledged by the poll |

## Verification
Every cycle, the assertions check four things. A start byte clears the mode state in the following cycle. A normal odd write lands in imr. The command strobes never overlap. A poll acknowledge or a trigger-mode change appears only after its own read or write. Only the bench's scenarios can show the rest. That covers the initialization byte counting for each combination of the cascade and mode-byte flags, and the guarded updates in the select command (bit 1 and bit 6 enables). It also covers the read data under poll and read select, and the per-bit writable mask on both a master and a slave instance.

// File: rtl/pic_regif_pkg.sv
package pic_regif_pkg;
  localparam int BYTE_W = 8;
  localparam int LINE_W = 3;

  typedef enum logic [1:0] {
    INIT_RUN  = 2'd0,
    INIT_BASE = 2'd1,
    INIT_CASC = 2'd2,
    INIT_MODE = 2'd3
  } init_st_e;

  localparam logic [2:0] OP_ROT_CLR    = 3'b000;
  localparam logic [2:0] OP_NS_EOI     = 3'b001;
  localparam logic [2:0] OP_NOP        = 3'b010;
  localparam logic [2:0] OP_SP_EOI     = 3'b011;
  localparam logic [2:0] OP_ROT_SET    = 3'b100;
  localparam logic [2:0] OP_ROT_NS_EOI = 3'b101;
  localparam logic [2:0] OP_SET_PRIO   = 3'b110;
  localparam logic [2:0] OP_ROT_SP_EOI = 3'b111;
endpackage

// File: rtl/pic_icw_seq.sv
module pic_icw_seq
  import pic_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_even,
  input  logic              wr_odd,
  input  logic [BYTE_W-1:0] wdata,
  output logic              icw1_hit,
  output logic              init_clr,
  output logic [BYTE_W-1:0] imr,
  output logic [BYTE_W-1:0] vec_base,
  output logic [BYTE_W-1:0] casc_cfg,
  output logic              sfnm,
  output logic              auto_eoi,
  output logic              init_busy
);
  init_st_e          st_q, st_d;
  logic              need4_q, need4_d, casc_q, casc_d;
  logic [BYTE_W-1:0] imr_d, base_d, ccfg_d;
  logic              sfnm_d, aeoi_d, en;

  assign icw1_hit = wr_even & wdata[4];
  assign en       = icw1_hit | wr_odd;

  always_comb begin
    st_d = st_q; need4_d = need4_q; casc_d = casc_q;
    imr_d = imr; base_d = vec_base; ccfg_d = casc_cfg;
    sfnm_d = sfnm; aeoi_d = auto_eoi;
    if (icw1_hit) begin
      st_d    = INIT_BASE;
      need4_d = wdata[0];
      casc_d  = ~wdata[1];
      imr_d   = '0;
      sfnm_d  = 1'b0;
      aeoi_d  = 1'b0;
    end else if (wr_odd) begin
      unique case (st_q)
        INIT_RUN:  imr_d = wdata;
        INIT_BASE: begin
          base_d = {wdata[BYTE_W-1:3], 3'b000};
          st_d   = casc_q ? INIT_CASC : (need4_q ? INIT_MODE : INIT_RUN);
        end
        INIT_CASC: begin
          ccfg_d = wdata;
          st_d   = need4_q ? INIT_MODE : INIT_RUN;
        end
        INIT_MODE: begin
          sfnm_d = wdata[4];
          aeoi_d = wdata[1];
          st_d   = INIT_RUN;
        end
        default: st_d = INIT_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= INIT_RUN; need4_q <= 1'b0; casc_q <= 1'b0;
      imr <= '0; vec_base <= '0; casc_cfg <= '0;
      sfnm <= 1'b0; auto_eoi <= 1'b0;
    end else if (en) begin
      st_q <= st_d; need4_q <= need4_d; casc_q <= casc_d;
      imr <= imr_d; vec_base <= base_d; casc_cfg <= ccfg_d;
      sfnm <= sfnm_d; auto_eoi <= aeoi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) init_clr <= 1'b0;
    else        init_clr <= icw1_hit;
  end

  assign init_busy = (st_q != INIT_RUN);
endmodule

// File: rtl/pic_ocw_dec.sv
module pic_ocw_dec
  import pic_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_even,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              icw1_hit,
  input  logic              poll_take,
  input  logic              core_req_valid,
  input  logic [LINE_W-1:0] core_req_line,
  output logic              read_isr,
  output logic              special_mask,
  output logic              poll_arm,
  output logic              rot_aeoi,
  output logic              eoi_ns,
  output logic              eoi_sp,
  output logic              eoi_rot,
  output logic              prio_set,
  output logic [LINE_W-1:0] cmd_line,
  output logic              poll_ack,
  output logic [LINE_W-1:0] poll_line
);
  logic              ocw2, ocw3;
  logic              rsel_d, smm_d, poll_d, rot_d;
  logic              ns_d, sp_d, er_d, pr_d, ack_d;
  logic [LINE_W-1:0] line_d, pline_d;

  assign ocw3 = wr_even & ~wdata[4] &  wdata[3];
  assign ocw2 = wr_even & ~wdata[4] & ~wdata[3];

  always_comb begin
    rsel_d = read_isr; smm_d = special_mask; poll_d = poll_arm; rot_d = rot_aeoi;
    ns_d = 1'b0; sp_d = 1'b0; er_d = 1'b0; pr_d = 1'b0;
    line_d = cmd_line; ack_d = 1'b0; pline_d = poll_line;
    if (poll_take) begin
      poll_d  = 1'b0;
      ack_d   = core_req_valid;
      pline_d = core_req_line;
    end
    if (icw1_hit) begin
      rsel_d = 1'b0; smm_d = 1'b0; poll_d = 1'b0; rot_d = 1'b0;
    end else if (ocw3) begin
      if (wdata[1]) rsel_d = wdata[0];
      if (wdata[6]) smm_d  = wdata[5];
      poll_d = wdata[2];
    end else if (ocw2) begin
      unique case (wdata[7:5])
        OP_ROT_CLR:    rot_d = 1'b0;
        OP_ROT_SET:    rot_d = 1'b1;
        OP_NS_EOI:     ns_d  = 1'b1;
        OP_ROT_NS_EOI: begin ns_d = 1'b1; er_d = 1'b1; end
        OP_SP_EOI:     begin sp_d = 1'b1; line_d = wdata[2:0]; end
        OP_ROT_SP_EOI: begin sp_d = 1'b1; er_d = 1'b1; line_d = wdata[2:0]; end
        OP_SET_PRIO:   begin pr_d = 1'b1; line_d = wdata[2:0]; end
        OP_NOP:        ;
        default:       ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      read_isr <= 1'b0; special_mask <= 1'b0; poll_arm <= 1'b0; rot_aeoi <= 1'b0;
      eoi_ns <= 1'b0; eoi_sp <= 1'b0; eoi_rot <= 1'b0; prio_set <= 1'b0;
      cmd_line <= '0; poll_ack <= 1'b0; poll_line <= '0;
    end else begin
      read_isr <= rsel_d; special_mask <= smm_d; poll_arm <= poll_d; rot_aeoi <= rot_d;
      eoi_ns <= ns_d; eoi_sp <= sp_d; eoi_rot <= er_d; prio_set <= pr_d;
      cmd_line <= line_d; poll_ack <= ack_d; poll_line <= pline_d;
    end
  end
endmodule

// File: rtl/pic_trig_reg.sv
module pic_trig_reg
  import pic_regif_pkg::*;
#(
  parameter logic [BYTE_W-1:0] WMASK = 8'hF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] q
);
  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    if (WMASK[i]) begin : g_rw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q[i] <= 1'b0;
        else if (wr) q[i] <= wdata[i];
      end
    end else begin : g_ro
      assign q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/pic_regif.sv
module pic_regif
  import pic_regif_pkg::*;
#(
  parameter logic [BYTE_W-1:0] TRIG_WMASK = 8'hF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic [BYTE_W-1:0] core_irr,
  input  logic [BYTE_W-1:0] core_isr,
  input  logic              core_req_valid,
  input  logic [LINE_W-1:0] core_req_line,
  input  logic              trig_wr,
  input  logic [BYTE_W-1:0] trig_wdata,
  output logic [BYTE_W-1:0] trig_mode,
  output logic [BYTE_W-1:0] imr,
  output logic [BYTE_W-1:0] vec_base,
  output logic [BYTE_W-1:0] casc_cfg,
  output logic              init_busy,
  output logic              init_clr,
  output logic              sfnm,
  output logic              auto_eoi,
  output logic              rot_aeoi,
  output logic              read_isr,
  output logic              special_mask,
  output logic              eoi_ns,
  output logic              eoi_sp,
  output logic              eoi_rot,
  output logic              prio_set,
  output logic [LINE_W-1:0] cmd_line,
  output logic              poll_ack,
  output logic [LINE_W-1:0] poll_line
);
  logic [1:0] rst_pipe;
  logic       rst_sn, wr_even, wr_odd, icw1_hit, poll_arm, poll_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  assign wr_even   = wr_en & ~addr;
  assign wr_odd    = wr_en &  addr;
  assign poll_take = rd_en & ~addr & poll_arm;

  pic_icw_seq u_icw (
    .clk(clk), .rst_n(rst_sn), .wr_even(wr_even), .wr_odd(wr_odd), .wdata(wdata),
    .icw1_hit(icw1_hit), .init_clr(init_clr), .imr(imr), .vec_base(vec_base),
    .casc_cfg(casc_cfg), .sfnm(sfnm), .auto_eoi(auto_eoi), .init_busy(init_busy)
  );

  pic_ocw_dec u_ocw (
    .clk(clk), .rst_n(rst_sn), .wr_even(wr_even), .wdata(wdata), .icw1_hit(icw1_hit),
    .poll_take(poll_take), .core_req_valid(core_req_valid), .core_req_line(core_req_line),
    .read_isr(read_isr), .special_mask(special_mask), .poll_arm(poll_arm),
    .rot_aeoi(rot_aeoi), .eoi_ns(eoi_ns), .eoi_sp(eoi_sp), .eoi_rot(eoi_rot),
    .prio_set(prio_set), .cmd_line(cmd_line), .poll_ack(poll_ack), .poll_line(poll_line)
  );

  pic_trig_reg #(.WMASK(TRIG_WMASK)) u_trig (
    .clk(clk), .rst_n(rst_sn), .wr(trig_wr), .wdata(trig_wdata), .q(trig_mode)
  );

  always_comb begin
    if (addr)          rdata = imr;
    else if (poll_arm) rdata = core_req_valid ? {5'b10000, core_req_line} : 8'h07;
    else if (read_isr) rdata = core_isr;
    else               rdata = core_irr;
  end
endmodule

// File: rtl/pic_regif_chk.sv
module pic_regif_chk (
  input logic       clk,
  input logic       rst_sn,
  input logic       wr_en,
  input logic       rd_en,
  input logic       addr,
  input logic [7:0] wdata,
  input logic       trig_wr,
  input logic [7:0] trig_mode,
  input logic [7:0] imr,
  input logic       init_busy,
  input logic       init_clr,
  input logic       sfnm,
  input logic       auto_eoi,
  input logic       read_isr,
  input logic       eoi_ns,
  input logic       eoi_sp,
  input logic       prio_set,
  input logic       poll_ack
);
  a_r1_init_clears: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_en && !addr && wdata[4]) |=>
      (imr == 8'h00 && init_busy && init_clr && !read_isr && !sfnm && !auto_eoi));

  a_r1_clr_cause: assert property (@(posedge clk) disable iff (!rst_sn)
    init_clr |-> $past(wr_en && !addr && wdata[4]));

  a_r5_imr_load: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_en && addr && !init_busy) |=> (imr == $past(wdata)));

  a_r8_strobe_excl: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0({eoi_ns, eoi_sp, prio_set}));

  a_r10_ack_cause: assert property (@(posedge clk) disable iff (!rst_sn)
    poll_ack |-> $past(rd_en && !addr));

  a_r11_trig_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    !trig_wr |=> $stable(trig_mode));
endmodule

bind pic_regif pic_regif_chk u_chk (
  .clk(clk), .rst_sn(rst_sn), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
  .trig_wr(trig_wr), .trig_mode(trig_mode), .imr(imr), .init_busy(init_busy),
  .init_clr(init_clr), .sfnm(sfnm), .auto_eoi(auto_eoi), .read_isr(read_isr),
  .eoi_ns(eoi_ns), .eoi_sp(eoi_sp), .prio_set(prio_set), .poll_ack(poll_ack)
);

// File: tb/pic_regif_tb_top.sv
module pic_regif_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0, core_irr = '0, core_isr = '0, trig_wdata = '0;
  logic       core_req_valid = 1'b0, trig_wr = 1'b0;
  logic [2:0] core_req_line = '0;

  logic [7:0] rdata, trig_mode, imr, vec_base, casc_cfg;
  logic       init_busy, init_clr, sfnm, auto_eoi, rot_aeoi, read_isr, special_mask;
  logic       eoi_ns, eoi_sp, eoi_rot, prio_set, poll_ack;
  logic [2:0] cmd_line, poll_line;

  logic [7:0] s_rdata, s_trig, s_imr, s_base, s_casc;
  logic       s_busy, s_clr, s_sfnm, s_aeoi, s_rot, s_rsel, s_smm, s_ns, s_sp, s_er, s_pr, s_ack;
  logic [2:0] s_line, s_pline;

  int nchk = 0, nerr = 0;

  always #2 clk = ~clk;

  pic_regif #(.TRIG_WMASK(8'hF8)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .core_irr(core_irr), .core_isr(core_isr), .core_req_valid(core_req_valid),
    .core_req_line(core_req_line), .trig_wr(trig_wr), .trig_wdata(trig_wdata),
    .trig_mode(trig_mode), .imr(imr), .vec_base(vec_base), .casc_cfg(casc_cfg),
    .init_busy(init_busy), .init_clr(init_clr), .sfnm(sfnm), .auto_eoi(auto_eoi),
    .rot_aeoi(rot_aeoi), .read_isr(read_isr), .special_mask(special_mask),
    .eoi_ns(eoi_ns), .eoi_sp(eoi_sp), .eoi_rot(eoi_rot), .prio_set(prio_set),
    .cmd_line(cmd_line), .poll_ack(poll_ack), .poll_line(poll_line)
  );

  pic_regif #(.TRIG_WMASK(8'hDE)) dut_s (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(s_rdata), .core_irr(core_irr), .core_isr(core_isr), .core_req_valid(core_req_valid),
    .core_req_line(core_req_line), .trig_wr(trig_wr), .trig_wdata(trig_wdata),
    .trig_mode(s_trig), .imr(s_imr), .vec_base(s_base), .casc_cfg(s_casc),
    .init_busy(s_busy), .init_clr(s_clr), .sfnm(s_sfnm), .auto_eoi(s_aeoi),
    .rot_aeoi(s_rot), .read_isr(s_rsel), .special_mask(s_smm),
    .eoi_ns(s_ns), .eoi_sp(s_sp), .eoi_rot(s_er), .prio_set(s_pr),
    .cmd_line(s_line), .poll_ack(s_ack), .poll_line(s_pline)
  );

  function automatic logic [7:0] exp_trig(input logic [7:0] d, input logic [7:0] m);
    return d & m;
  endfunction

  function automatic logic [7:0] exp_even(input logic sel, input logic [7:0] irr,
                                          input logic [7:0] isr);
    return sel ? isr : irr;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic twr(input logic [7:0] d);
    @(negedge clk); trig_wdata = d; trig_wr = 1'b1;
    @(negedge clk); trig_wr = 1'b0;
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
  endtask

  initial begin
    #(4 * 200000);
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] m;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    rd(1'b1, v);
    chk("R5 reset imr", v, 8'h00);
    chk("R3 reset init_busy", init_busy, 0);
    chk("R11 reset trig", trig_mode, 0);

    // cascade + mode byte
    wr(1'b0, 8'h11);
    chk("R1 init_clr pulse", init_clr, 1);
    chk("R1 init_busy set", init_busy, 1);
    @(negedge clk);
    chk("R1 init_clr one cycle", init_clr, 0);
    wr(1'b1, 8'h6D);
    chk("R2 vec_base", vec_base, 8'h68);
    chk("R3 waits cascade", init_busy, 1);
    wr(1'b1, 8'h04);
    chk("R3 casc_cfg", casc_cfg, 8'h04);
    chk("R3 waits mode", init_busy, 1);
    wr(1'b1, 8'h12);
    chk("R4 sfnm", sfnm, 1);
    chk("R4 auto_eoi", auto_eoi, 1);
    chk("R3 done", init_busy, 0);

    wr(1'b1, 8'hA5);
    rd(1'b1, v);
    chk("R5 imr read", v, 8'hA5);
    wr(1'b0, 8'h0B);
    chk("R6 read select", read_isr, 1);
    wr(1'b0, 8'h80);
    chk("R9 rot set", rot_aeoi, 1);

    // single, no mode byte
    wr(1'b0, 8'h12);
    chk("R1 imr clear", imr, 0);
    chk("R1 read_isr clear", read_isr, 0);
    chk("R1 sfnm clear", sfnm, 0);
    chk("R1 aeoi clear", auto_eoi, 0);
    chk("R1 rot clear", rot_aeoi, 0);
    wr(1'b1, 8'h27);
    chk("R2 vec_base low forced", vec_base, 8'h20);
    chk("R3 no cascade no mode", init_busy, 0);
    chk("R3 casc_cfg kept", casc_cfg, 8'h04);

    // cascade, no mode byte
    wr(1'b0, 8'h10);
    wr(1'b1, 8'h08);
    chk("R3 wait cascade only", init_busy, 1);
    wr(1'b1, 8'h02);
    chk("R3 casc only done", init_busy, 0);
    chk("R3 casc_cfg new", casc_cfg, 8'h02);
    chk("R4 mode untouched", sfnm, 0);

    // select command guards
    wr(1'b0, 8'h09);
    chk("R6 bit1 guard", read_isr, 0);
    wr(1'b0, 8'h68);
    chk("R6 smm set", special_mask, 1);
    wr(1'b0, 8'h28);
    chk("R6 bit6 guard", special_mask, 1);
    wr(1'b0, 8'h48);
    chk("R6 smm clear", special_mask, 0);

    // order commands
    wr(1'b0, 8'h20);
    chk("R8 ns eoi", {eoi_ns, eoi_sp, eoi_rot, prio_set}, 4'b1000);
    @(negedge clk);
    chk("R8 strobe one cycle", eoi_ns, 0);
    wr(1'b0, 8'hA0);
    chk("R8 rot ns eoi", {eoi_ns, eoi_sp, eoi_rot, prio_set}, 4'b1010);
    wr(1'b0, 8'h63);
    chk("R8 sp eoi", {eoi_ns, eoi_sp, eoi_rot, prio_set}, 4'b0100);
    chk("R8 sp line", cmd_line, 3);
    wr(1'b0, 8'hE6);
    chk("R8 rot sp eoi", {eoi_ns, eoi_sp, eoi_rot, prio_set}, 4'b0110);
    chk("R8 rot sp line", cmd_line, 6);
    wr(1'b0, 8'hC2);
    chk("R8 set prio", {eoi_ns, eoi_sp, eoi_rot, prio_set}, 4'b0001);
    chk("R8 prio line", cmd_line, 2);
    wr(1'b0, 8'h45);
    chk("R8 nop", {eoi_ns, eoi_sp, eoi_rot, prio_set}, 4'b0000);
    chk("R8 nop line kept", cmd_line, 2);
    wr(1'b0, 8'h80);
    chk("R9 rot set no strobe", {rot_aeoi, eoi_ns, eoi_sp, prio_set}, 4'b1000);
    wr(1'b0, 8'h00);
    chk("R9 rot clear", rot_aeoi, 0);

    // poll
    core_irr = 8'h3C; core_req_valid = 1'b1; core_req_line = 3'd5;
    wr(1'b0, 8'h0C);
    rd(1'b0, v);
    chk("R10 poll data", v, 8'h85);
    chk("R10 poll ack", poll_ack, 1);
    chk("R10 poll line", poll_line, 5);
    rd(1'b0, v);
    chk("R10 poll disarmed", v, 8'h3C);
    chk("R10 no ack unarmed", poll_ack, 0);
    core_req_valid = 1'b0;
    wr(1'b0, 8'h0C);
    rd(1'b0, v);
    chk("R10 poll empty", v, 8'h07);
    chk("R10 empty no ack", poll_ack, 0);

    // random mix
    for (int i = 0; i < 40; i++) begin
      logic sel;
      m = 8'($urandom);
      wr(1'b1, m);
      rd(1'b1, v);
      chk("R5 random imr", v, m);
      core_irr = 8'($urandom); core_isr = 8'($urandom);
      sel = 1'($urandom);
      wr(1'b0, {7'b0000101, sel});
      rd(1'b0, v);
      chk("R7 random even read", v, exp_even(sel, core_irr, core_isr));
      m = 8'($urandom);
      twr(m);
      chk("R11 master trig", trig_mode, exp_trig(m, 8'hF8));
      chk("R11 slave trig", s_trig, exp_trig(m, 8'hDE));
    end

    summary();
    $finish;
  end
endmodule